// File: doc/BRIEF.md
# PHY-Side Link Interface Sequencer

This block sits on the PHY side of a 4-bit parallel PHY-to-link interface clocked by one system clock. The interface has 2 control lines and 4 data lines, and the two sides take turns driving them. Two jobs need the lines:

- **Receive forwarding.** When a packet arrives from the serial bus, the block announces it to the link. It sends an all-ones preamble, then a one-nibble speed code, then the packet data, and ends with idle.
- **Transmit grant.** When the arbitration logic reports that the node has won the bus, the block drives a grant pattern and then releases the lines. While the link owns the lines, the block follows the link's control codes: hold, transmit and end. It passes the link's transmit nibbles on as decoded data.

**Control codes, PHY driving:** 00 idle, 10 receive, 11 grant.

**Control codes, link driving:** 00 idle/end, 01 hold, 10 transmit; 11 is not a valid link code.

**Receive stream:** `rx_valid` stays high on consecutive clocks from the first unit of a packet to the unit flagged by `rx_eop`. `rx_s200` gives the packet speed on the first unit.

**Chained packets:** a link that ends a packet with hold, instead of idle, keeps the bus for a further packet. The block answers that with a fresh grant.

Top module: `phy_link_seq`

## Requirements
- R1: During and right after reset the block drives the lines with control 00 and data 0000, both output enables are 1, and `tx_valid`, `tx_hold`, `tx_done` and `tx_data` are 0.
- R2: A first `rx_valid` seen in idle makes the next clock show control 10 with data 1111. The clock after that shows control 10 with the speed code: 0000 for a 100 Mb/s packet (`rx_s200`=0) or 0100 for a 200 Mb/s packet (`rx_s200`=1).
- R3: Data unit j of a packet appears on the data lines with control 10 exactly three clocks after it was presented, in arrival order. At 200 Mb/s the whole nibble is placed on the data lines. At 100 Mb/s bits 1:0 carry `rx_data[1:0]` and bits 3:2 are 0.
- R4: On the clock after the last data unit, the block drives control 00 with data 0000 and keeps driving.
- R5: A `gnt_req` sampled in idle with `rx_valid` low gives GNT_LEN clocks of control 11 with data 0000, then one clock of control 00, then both output enables at 0.
- R6: `rx_valid` takes priority over a coincident `gnt_req`, and a `gnt_req` outside idle is ignored: the lines stay idle once the receive ends.
- R7: While the link owns the lines, control 10 from the link gives `tx_valid`=1 and `tx_data` equal to the link's data, one clock later.
- R8: While the link owns the lines, control 01 from the link gives `tx_hold`=1 and `tx_valid`=0 one clock later, and the lines stay released.
- R9: After at least one transmit clock, link control 00 gives a `tx_done` pulse one clock later. The enables stay 0 for that clock, and the block drives control 00 again on the clock after.
- R10: After at least one transmit clock, link control 01 gives `tx_done` and `tx_hold` one clock later. The enables stay 0 for that clock, and a new grant (control 11) starts on the clock after.
- R11: Link control and data lines have no effect on `tx_valid`, `tx_hold`, `tx_done` or the driven lines while the block owns the interface.
- R12: Link control 11 is ignored: it raises no transmit output and the lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received unit valid this clock |
| rx_s200 | input | 1 | Packet speed: 1 = 200 Mb/s, 0 = 100 Mb/s |
| rx_data | input | 4 | Received unit (bits 1:0 only at 100 Mb/s) |
| rx_eop | input | 1 | Marks the last unit of the packet |
| gnt_req | input | 1 | Arbitration won: grant the bus to the link |
| ctl_i | input | 2 | Control lines as driven by the link |
| d_i | input | 4 | Data lines as driven by the link |
| ctl_o | output | 2 | Control lines driven by the block |
| ctl_oe | output | 1 | Output enable for the control lines |
| d_o | output | 4 | Data lines driven by the block |
| d_oe | output | 1 | Output enable for the data lines |
| tx_valid | output | 1 | Decoded link transmit nibble valid |
| tx_data | output | 4 | Decoded link transmit nibble |
| tx_hold | output | 1 | Link is holding the bus |
| tx_done | output | 1 | Link has ended its packet |

## Verification
The assertions rely on three properties of the inputs:

- **Contiguous receive stream.** `rx_valid` stays high from the first unit to `rx_eop`, and at least three clocks without `rx_valid` pass before a new packet.
- **No overlap of receive and link ownership.** `gnt_req` never coincides with a receive that arrives while the link owns the lines.
- **Quiet release clock.** In the clock where it has released the lines, the link leaves control at 00.

The bench keeps within these rules. Packets are sent back to back with a four-clock gap. Grants are issued only while the lines are idle. The modelled link drives zero after its end code. Deliberately noisy link lines are presented only while the block owns the interface.

// File: rtl/phy_link_seq.sv
module phy_link_seq #(
  parameter int GNT_LEN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_s200,
  input  logic [3:0] rx_data,
  input  logic       rx_eop,
  input  logic       gnt_req,
  input  logic [1:0] ctl_i,
  input  logic [3:0] d_i,
  output logic [1:0] ctl_o,
  output logic       ctl_oe,
  output logic [3:0] d_o,
  output logic       d_oe,
  output logic       tx_valid,
  output logic [3:0] tx_data,
  output logic       tx_hold,
  output logic       tx_done
);

  localparam int PIPE = 3;
  localparam int GCW  = (GNT_LEN > 1) ? $clog2(GNT_LEN) : 1;
  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_HOLD = 2'b01;
  localparam logic [1:0] C_XFER = 2'b10;
  localparam logic [1:0] C_GRNT = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_SPD, S_DAT, S_GNT, S_GEND, S_LINK, S_TURN
  } st_t;

  st_t            st;
  logic           s200_q;
  logic           sent_q;
  logic           regnt_q;
  logic [GCW-1:0] gcnt;
  logic [3:0]     pd_q [PIPE];
  logic           pe_q [PIPE];

  wire in_link  = (st == S_LINK);
  wire link_tx  = in_link && (ctl_i == C_XFER);
  wire link_hld = in_link && (ctl_i == C_HOLD);
  wire link_end = in_link && sent_q && (ctl_i == C_IDLE || ctl_i == C_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PIPE; i++) begin
        pd_q[i] <= '0;
        pe_q[i] <= 1'b0;
      end
    end else begin
      pd_q[0] <= rx_data;
      pe_q[0] <= rx_valid & rx_eop;
      for (int i = 1; i < PIPE; i++) begin
        pd_q[i] <= pd_q[i-1];
        pe_q[i] <= pe_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      s200_q  <= 1'b0;
      sent_q  <= 1'b0;
      regnt_q <= 1'b0;
      gcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          // receive wins over a coincident grant request (R6)
          if (rx_valid) begin
            st     <= S_PRE;
            s200_q <= rx_s200;
          end else if (gnt_req) begin
            st   <= S_GNT;
            gcnt <= '0;
          end
        end
        S_PRE:  st <= S_SPD;
        S_SPD:  st <= S_DAT;
        S_DAT:  if (pe_q[PIPE-1]) st <= S_IDLE;
        S_GNT: begin
          if (gcnt == GCW'(GNT_LEN - 1)) st <= S_GEND;
          else                           gcnt <= gcnt + 1'b1;
        end
        S_GEND: begin
          st     <= S_LINK;
          sent_q <= 1'b0;
        end
        S_LINK: begin
          if (link_tx) sent_q <= 1'b1;
          else if (link_end) begin
            st      <= S_TURN;
            regnt_q <= (ctl_i == C_HOLD);
          end
        end
        S_TURN: begin
          if (regnt_q) begin
            st   <= S_GNT;
            gcnt <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_hold  <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_valid <= link_tx;
      tx_data  <= link_tx ? d_i : 4'h0;
      tx_hold  <= link_hld;
      tx_done  <= link_end;
    end
  end

  wire [3:0] rx_word = s200_q ? pd_q[PIPE-1] : {2'b00, pd_q[PIPE-1][1:0]};

  always_comb begin
    ctl_o = C_IDLE;
    d_o   = 4'h0;
    case (st)
      S_PRE: begin ctl_o = C_XFER; d_o = 4'hF; end
      S_SPD: begin ctl_o = C_XFER; d_o = s200_q ? 4'h4 : 4'h0; end
      S_DAT: begin ctl_o = C_XFER; d_o = rx_word; end
      S_GNT: ctl_o = C_GRNT;
      default: ;
    endcase
  end

  assign ctl_oe = (st != S_LINK) && (st != S_TURN);
  assign d_oe   = ctl_oe;

endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_o,
  input logic       ctl_oe,
  input logic [3:0] d_o,
  input logic [1:0] ctl_i,
  input logic [3:0] d_i,
  input logic       tx_valid,
  input logic [3:0] tx_data,
  input logic       tx_hold,
  input logic       tx_done
);

  logic [1:0] ctl1, ctl2, ci1;
  logic [3:0] di1;
  logic       oe1, oe2, s100_seen;

  wire rx0 = ctl_oe && ctl_o == 2'b10;
  wire rx1 = oe1 && ctl1 == 2'b10;
  wire rx2 = oe2 && ctl2 == 2'b10;
  wire g1  = oe1 && ctl1 == 2'b11;
  wire g2  = oe2 && ctl2 == 2'b11;
  wire pre_cyc = rx0 && !rx1;
  wire spd_cyc = rx0 && rx1 && !rx2;
  wire dat_cyc = rx0 && rx1 && rx2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= 2'b00; ctl2 <= 2'b00; oe1 <= 1'b1; oe2 <= 1'b1;
      ci1 <= 2'b00; di1 <= 4'h0; s100_seen <= 1'b0;
    end else begin
      ctl1 <= ctl_o; ctl2 <= ctl1; oe1 <= ctl_oe; oe2 <= oe1;
      ci1 <= ctl_i; di1 <= d_i;
      if (spd_cyc) s100_seen <= (d_o == 4'h0);
    end
  end

  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n) pre_cyc |-> d_o == 4'hF); // R2
  AST_SPEED_CODE: assert property (@(posedge clk) disable iff (!rst_n) spd_cyc |-> (d_o == 4'h0 || d_o == 4'h4)); // R2
  AST_S100_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n) (dat_cyc && s100_seen) |-> d_o[3:2] == 2'b00); // R3
  AST_RX_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) (rx1 && !rx0) |-> (ctl_oe && ctl_o == 2'b00 && d_o == 4'h0)); // R4
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (g1 && !(ctl_oe && ctl_o == 2'b11)) |-> (ctl_oe && ctl_o == 2'b00)); // R5
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (g2 && oe1 && ctl1 == 2'b00) |-> !ctl_oe); // R5
  AST_TX_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> (ci1 == 2'b10 && tx_data == di1)); // R7
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n) tx_hold |-> (ci1 == 2'b01 && !tx_valid)); // R8
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n) (ctl_oe && !oe1) |-> !oe2); // R9
  AST_DONE_RESUME: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> ctl_oe); // R9
  AST_REGRANT: assert property (@(posedge clk) disable iff (!rst_n) (tx_done && ci1 == 2'b01) |=> (ctl_oe && ctl_o == 2'b11)); // R10
  AST_TX_LINK_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid || tx_hold || tx_done) |-> !oe1); // R11
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!oe1 && ci1 == 2'b11) |-> (!tx_valid && !tx_hold && !tx_done && !ctl_oe)); // R12

endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o),
  .ctl_i(ctl_i), .d_i(d_i), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_hold(tx_hold), .tx_done(tx_done)
);

// File: tb/sim_phy_link_seq.sv
module sim_phy_link_seq;
  localparam int GL = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       rx_valid = 0, rx_s200 = 0, rx_eop = 0, gnt_req = 0;
  logic [3:0] rx_data = 0;
  logic [1:0] ctl_i = 0;
  logic [3:0] d_i = 0;
  logic [1:0] ctl_o;
  logic [3:0] d_o, tx_data;
  logic       ctl_oe, d_oe, tx_valid, tx_hold, tx_done;

  phy_link_seq #(.GNT_LEN(GL)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_s200(rx_s200),
    .rx_data(rx_data), .rx_eop(rx_eop), .gnt_req(gnt_req), .ctl_i(ctl_i),
    .d_i(d_i), .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o), .d_oe(d_oe),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_hold(tx_hold), .tx_done(tx_done)
  );

  wire [6:0] bus = {ctl_oe, ctl_o, d_o};
  wire [3:0] txs = {tx_valid, tx_hold, tx_done, |tx_data};
  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input int seed, input int j);
    return 4'((seed + 7 * j) % 16);
  endfunction

  task automatic rx_pkt(input int len, input bit s200, input int seed, input bit with_gnt);
    for (int k = 0; k <= len + 3; k++) begin
      @(negedge clk);
      if (k == 1) chk("R2 preamble", bus, {1'b1, 2'b10, 4'hF});
      else if (k == 2) chk("R2 speed code", bus, {1'b1, 2'b10, (s200 ? 4'h4 : 4'h0)});
      else if (k >= 3 && k < len + 3) begin
        logic [3:0] e;
        e = nib(seed, k - 3);
        if (!s200) e = {2'b00, e[1:0]};
        chk("R3 data order/lanes", bus, {1'b1, 2'b10, e});
      end else if (k == len + 3) chk("R4 receive close", bus, {1'b1, 2'b00, 4'h0});
      if (k >= 1) chk("R11 link lines ignored", txs, 0);
      if (k < len) begin
        rx_valid = 1; rx_s200 = s200; rx_data = nib(seed, k);
        rx_eop = (k == len - 1); gnt_req = with_gnt;
      end else begin
        rx_valid = 0; rx_eop = 0; rx_data = 4'hA; gnt_req = 0;
      end
      ctl_i = 2'(k + 2); d_i = 4'(k * 3 + 1);
    end
    ctl_i = 0; d_i = 0;
  endtask

  task automatic grant_seq(input int already);
    for (int g = already; g < GL; g++) begin
      @(negedge clk);
      gnt_req = 0;
      chk("R5 grant code", bus, {1'b1, 2'b11, 4'h0});
    end
    @(negedge clk);
    chk("R5 grant close", bus, {1'b1, 2'b00, 4'h0});
    @(negedge clk);
    chk("R5 release ctl", ctl_oe, 0);
    chk("R5 release data", d_oe, 0);
  endtask

  task automatic grant_from_idle();
    @(negedge clk);
    gnt_req = 1;
    grant_seq(0);
  endtask

  task automatic tx_chk(input logic [1:0] pc, input logic [3:0] pd);
    chk("R7 tx_valid", tx_valid, (pc == 2'b10));
    chk("R7 tx_data", tx_data, (pc == 2'b10) ? pd : 4'h0);
    chk("R8 tx_hold", tx_hold, (pc == 2'b01));
    chk("R9 no early done", tx_done, 0);
  endtask

  task automatic link_tx(input int nh, input int nbad, input int nd, input bit concat, input int seed);
    logic [1:0] pc;
    logic [3:0] pd;
    int total;
    total = nh + nbad + nd + 1;
    pc = 0; pd = 0;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k > 0) tx_chk(pc, pd);
      if (pc == 2'b11) chk("R12 reserved keeps link owner", ctl_oe, 0);
      else chk("R8 link owns lines", ctl_oe, 0);
      if (k < nh) begin pc = 2'b01; pd = 4'(k + 9); end
      else if (k < nh + nbad) begin pc = 2'b11; pd = 4'hC; end
      else if (k < nh + nbad + nd) begin pc = 2'b10; pd = nib(seed, k - nh - nbad); end
      else begin pc = concat ? 2'b01 : 2'b00; pd = 4'h0; end
      ctl_i = pc; d_i = pd;
    end
    @(negedge clk);
    chk(concat ? "R10 done pulse" : "R9 done pulse", tx_done, 1);
    chk(concat ? "R10 hold flag" : "R9 hold flag", tx_hold, concat);
    chk("R9 turnaround released", ctl_oe, 0);
    ctl_i = 0; d_i = 0;
    @(negedge clk);
    if (concat) chk("R10 new grant", bus, {1'b1, 2'b11, 4'h0});
    else chk("R9 phy drives idle", bus, {1'b1, 2'b00, 4'h0});
    chk("R9 done single clock", tx_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", bus, {1'b1, 2'b00, 4'h0});
    chk("R1 reset data enable", d_oe, 1);
    chk("R1 reset tx outputs", txs, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", bus, {1'b1, 2'b00, 4'h0});
    chk("R1 tx quiet after reset", txs, 0);

    for (int s = 0; s < 2; s++)
      for (int len = 1; len <= 8; len++)
        rx_pkt(len, s[0], len * 11 + s, 0);
    rx_pkt(16, 1, 0, 0);
    rx_pkt(16, 0, 3, 0);

    rx_pkt(3, 1, 5, 1);
    @(negedge clk);
    chk("R6 grant ignored after receive", bus, {1'b1, 2'b00, 4'h0});
    @(negedge clk);
    chk("R6 still idle", bus, {1'b1, 2'b00, 4'h0});

    grant_from_idle();
    link_tx(2, 0, 4, 0, 3);
    grant_from_idle();
    link_tx(0, 0, 1, 0, 8);
    grant_from_idle();
    link_tx(1, 1, 5, 1, 2);
    grant_seq(1);
    link_tx(0, 2, 3, 0, 9);

    rx_pkt(4, 1, 6, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule